// File: doc/BRIEF.md
# Tick-Paced I2C Register Master

This block drives an I2C bus as its only master. It talks to a single slave whose 7-bit address is fixed when the block is instantiated. A host starts a transfer with a one-cycle `cmd_go` pulse. A write transfer puts one data byte into one slave register. A read transfer fetches a run of consecutive bytes, starting at a given register. Read bytes come back one at a time on `rd_data`, each marked by a one-cycle `rd_valid`. `busy` covers the whole transfer. `err` reports that the slave refused a byte.

The block has no clock divider of its own. An external enable, `tick`, sets the pace, and every internal state change other than accepting a command waits for it. A bit on the wire always uses three tick periods: SCL held low, then released high, then held low again. SCL therefore runs at one third of the tick rate. Both bus lines are open-drain. An output enable of 1 pulls a line to 0, and a released line is pulled up outside the block. SDA is read back on `sda_i` to pick up acknowledges and read data.

Top module: `i2c_tick_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `err` and `rd_valid` are all 0, so both lines are released.
- R2: Each bit slot, including the START and STOP slots, lasts exactly three tick periods. During a write, consecutive rising edges of SCL are exactly three ticks apart, and a write produces 28 SCL rising edges.
- R3: While `tick` is low, no state advances: `scl_oe`, `sda_oe` and `busy` hold their values, and the transfer then completes unchanged once ticks resume.
- R4: SDA changes only while SCL is low, with two exceptions. In a START, SDA falls while SCL is high. In a STOP, SDA rises while SCL is high. A write therefore has exactly 2 SDA changes with SCL high, and a read has exactly 3.
- R5: A write (`cmd_rd`=0) sends START, the address byte {SLV_ADDR, 0}, the register byte, the data byte, then STOP. Every byte is sent MSB first and is followed by an acknowledge slot in which the master releases SDA.
- R6: A read (`cmd_rd`=1) sends START, {SLV_ADDR, 0}, the register byte, a repeated START, {SLV_ADDR, 1}, then clocks in the requested number of bytes MSB first, then sends STOP. A read produces 29 + 9×N SCL rising edges for N bytes.
- R7: In a read, the master pulls SDA low in the acknowledge slot of every byte except the last. In the acknowledge slot of the last byte it leaves SDA released (NACK).
- R8: Each read byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in bus order. A `cmd_len` of 0 is treated as 1.
- R9: When the slave leaves SDA high in the acknowledge slot of an address, register or write-data byte, the master goes straight to STOP, sets `err`, and returns to idle. No further byte is sent. `err` clears when the next command is accepted.
- R10: `busy` is high from the cycle after an accepted `cmd_go` until the STOP slot ends. `cmd_go` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Step enable at three times the SCL rate |
| cmd_go | input | 1 | Start a transfer (accepted only when idle) |
| cmd_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_reg | input | 8 | Slave register address |
| cmd_wdata | input | 8 | Byte to write |
| cmd_len | input | $clog2(MAX_RD+1) | Number of bytes to read (0 means 1) |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last transfer ended on a slave NACK |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle strobe per read byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The assertions check the following on every cycle:
- without a tick, neither the phase counter nor the state machine moves;
- the phase always wraps after its third step;
- SDA stays steady while SCL is released inside a data or acknowledge slot;
- a refused byte always leads into STOP;
- `err` only rises out of an acknowledge slot;
- `rd_valid` is a single-cycle pulse;
- a command arriving while busy leaves the latched command untouched.

Only the bench scenarios can show the rest, because it depends on the whole transfer:
- the order and content of the bytes;
- the repeated START and the final NACK of a read;
- the three-tick spacing of SCL edges;
- the count of START and STOP conditions.

A bus-level slave model in the bench gathers all of this.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TXBIT,
    ST_TXACK,
    ST_RXBIT,
    ST_RXACK,
    ST_STOP
  } tm_state_e;

  // which byte the transmit/receive slots are working on
  typedef enum logic [2:0] {
    BY_ADDRW,
    BY_REG,
    BY_WDATA,
    BY_ADDRR,
    BY_RDATA
  } tm_byte_e;

  // the three phases of one bit slot
  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_C = 2'd2;

endpackage

// File: rtl/i2c_tm_rstsync.sv
module i2c_tm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_tm_phase.sv
module i2c_tm_phase import i2c_tm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  output logic [1:0] ph,
  output logic       mid_end,
  output logic       slot_end
);

  logic [1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run)      ph_d = PH_A;
    else if (tick) ph_d = (ph_q == PH_C) ? PH_A : ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_A;
    else        ph_q <= ph_d;
  end

  assign ph       = ph_q;
  assign mid_end  = run && tick && (ph_q == PH_B);
  assign slot_end = run && tick && (ph_q == PH_C);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && ph_q == PH_C) |=> (ph_q == PH_A)); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(ph_q)); // R3

endmodule

// File: rtl/i2c_tm_shift.sv
module i2c_tm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q,
  output logic         msb
);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q_q[W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q   = q_q;
  assign msb = q_q[W-1];

endmodule

// File: rtl/i2c_tick_master.sv
module i2c_tick_master import i2c_tm_pkg::*; #(
  parameter logic [6:0] SLV_ADDR = 7'h68,
  parameter int         MAX_RD   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        cmd_go,
  input  logic                        cmd_rd,
  input  logic [7:0]                  cmd_reg,
  input  logic [7:0]                  cmd_wdata,
  input  logic [$clog2(MAX_RD+1)-1:0] cmd_len,
  output logic                        busy,
  output logic                        err,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid,
  output logic                        scl_oe,
  output logic                        sda_oe,
  input  logic                        sda_i
);

  localparam int BYTE_W = 8;
  localparam int BITC_W = $clog2(BYTE_W);
  localparam int LEN_W  = $clog2(MAX_RD + 1);
  localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);

  logic rst_s;
  logic [1:0] ph;
  logic mid_end, slot_end;

  tm_state_e   state_q, state_d;
  tm_byte_e    kind_q, kind_d;
  logic [BITC_W-1:0] bitc_q, bitc_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic        is_rd_q, is_rd_d;
  logic [7:0]  reg_q, reg_d, wdat_q, wdat_d;
  logic        nack_q, nack_d, err_q, err_d, vld_q, vld_d;

  logic              sh_load, sh_shift, sh_in, sh_msb;
  logic [BYTE_W-1:0] sh_val, sh_q;
  logic              scl_low, sda_low, last_rd;

  i2c_tm_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_an(rst_n), .rst_sn(rst_s)
  );

  i2c_tm_phase u_ph (
    .clk(clk), .rst_n(rst_s), .tick(tick), .run(busy),
    .ph(ph), .mid_end(mid_end), .slot_end(slot_end)
  );

  i2c_tm_shift #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_s), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .shift_in(sh_in), .q(sh_q), .msb(sh_msb)
  );

  assign busy    = (state_q != ST_IDLE);
  assign last_rd = (rem_q == LEN_W'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;  kind_d = kind_q;   bitc_d = bitc_q;
    rem_d   = rem_q;    is_rd_d = is_rd_q; reg_d  = reg_q;
    wdat_d  = wdat_q;   nack_d = nack_q;   err_d  = err_q;
    vld_d   = 1'b0;
    sh_load = 1'b0;     sh_val = '0;       sh_shift = 1'b0; sh_in = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_go) begin
        is_rd_d = cmd_rd;
        reg_d   = cmd_reg;
        wdat_d  = cmd_wdata;
        rem_d   = (cmd_len == '0) ? LEN_W'(1) : cmd_len;
        err_d   = 1'b0;
        kind_d  = BY_ADDRW;
        state_d = ST_START;
      end
      ST_START: if (slot_end) begin
        sh_load = 1'b1;
        sh_val  = {SLV_ADDR, (kind_q == BY_ADDRR)};
        bitc_d  = '0;
        state_d = ST_TXBIT;
      end
      ST_TXBIT: if (slot_end) begin
        sh_shift = 1'b1;
        bitc_d   = bitc_q + 1'b1;
        if (bitc_q == LAST_BIT) state_d = ST_TXACK;
      end
      ST_TXACK: begin
        if (mid_end) nack_d = sda_i;
        if (slot_end) begin
          bitc_d = '0;
          if (nack_q) begin
            err_d   = 1'b1;
            state_d = ST_STOP;
          end else begin
            case (kind_q)
              BY_ADDRW: begin
                sh_load = 1'b1; sh_val = reg_q;
                kind_d = BY_REG; state_d = ST_TXBIT;
              end
              BY_REG: if (is_rd_q) begin
                kind_d = BY_ADDRR; state_d = ST_START;
              end else begin
                sh_load = 1'b1; sh_val = wdat_q;
                kind_d = BY_WDATA; state_d = ST_TXBIT;
              end
              BY_ADDRR: begin
                kind_d = BY_RDATA; state_d = ST_RXBIT;
              end
              default: state_d = ST_STOP;
            endcase
          end
        end
      end
      ST_RXBIT: begin
        if (mid_end) begin
          sh_shift = 1'b1;
          sh_in    = sda_i;
        end
        if (slot_end) begin
          bitc_d = bitc_q + 1'b1;
          if (bitc_q == LAST_BIT) begin
            vld_d   = 1'b1;
            state_d = ST_RXACK;
          end
        end
      end
      ST_RXACK: if (slot_end) begin
        bitc_d = '0;
        if (last_rd) state_d = ST_STOP;
        else begin
          rem_d   = rem_q - 1'b1;
          state_d = ST_RXBIT;
        end
      end
      ST_STOP: if (slot_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;  kind_q <= BY_ADDRW; bitc_q <= '0;
      rem_q   <= '0;       is_rd_q <= 1'b0;    reg_q  <= '0;
      wdat_q  <= '0;       nack_q <= 1'b0;     err_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;  kind_q <= kind_d;   bitc_q <= bitc_d;
      rem_q   <= rem_d;    is_rd_q <= is_rd_d; reg_q  <= reg_d;
      wdat_q  <= wdat_d;   nack_q <= nack_d;   err_q  <= err_d;
      vld_q   <= vld_d;
    end
  end

  // line decode: phase A = first low, B = high, C = second low
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (state_q)
      ST_START: begin scl_low = (ph == PH_C); sda_low = (ph != PH_A); end
      ST_STOP:  begin scl_low = (ph == PH_A); sda_low = (ph != PH_C); end
      ST_TXBIT: begin scl_low = (ph != PH_B); sda_low = ~sh_msb;      end
      ST_TXACK,
      ST_RXBIT: begin scl_low = (ph != PH_B); sda_low = 1'b0;         end
      ST_RXACK: begin scl_low = (ph != PH_B); sda_low = ~last_rd;     end
      default:  begin scl_low = 1'b0;         sda_low = 1'b0;         end
    endcase
  end

  assign scl_oe   = scl_low;
  assign sda_oe   = sda_low;
  assign err      = err_q;
  assign rd_valid = vld_q;
  assign rd_data  = sh_q;

  logic in_bit;
  assign in_bit = (state_q == ST_TXBIT) || (state_q == ST_TXACK) ||
                  (state_q == ST_RXBIT) || (state_q == ST_RXACK);

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && !tick) |=> $stable(state_q)); // R3

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    (in_bit && !scl_oe && $past(in_bit) && $past(!scl_oe)) |-> $stable(sda_oe)); // R4

  AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_TXACK && slot_end && nack_q) |=> (state_q == ST_STOP)); // R9

  AST_ERR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(err) |-> ($past(state_q) == ST_TXACK)); // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |=> !rd_valid); // R8

  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && cmd_go) |=> ($stable(is_rd_q) && $stable(reg_q) && $stable(wdat_q))); // R10

endmodule

// File: tb/sim_i2c_tick_master.sv
module sim_i2c_tick_master;

  localparam time CLK_PERIOD = 10ns;
  localparam int  TICK_DIV   = 4;
  localparam logic [6:0] ADDR = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmd_go = 1'b0, cmd_rd = 1'b0;
  logic [7:0] cmd_reg = '0, cmd_wdata = '0;
  logic [4:0] cmd_len = '0;
  logic busy, err, rd_valid, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic scl, sda;
  logic s_pull = 1'b0;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | s_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tick_master #(.SLV_ADDR(ADDR), .MAX_RD(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_go(cmd_go), .cmd_rd(cmd_rd),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .busy(busy), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda)
  );

  int checks = 0, errors = 0;

  // slave-model and monitor state
  logic [6:0] s_addr = ADDR;
  bit   hold = 1'b0, nack_reg = 1'b0, nack_wdata = 1'b0, iv_en = 1'b0;
  int   mode = 0, n = 0;
  bit   go_tx = 1'b0, m_ack = 1'b0;
  logic [7:0] rxb = '0, txb = '0, ptr = '0, last_addr = '0;
  logic [7:0] wlog_reg = '0, wlog_data = '0;
  int   wlog_cnt, start_cnt, stop_cnt, mack_cnt, mnack_cnt;
  int   rise_cnt, tick_since, bad_iv, hi_chg, got_n;
  logic [7:0] got [0:15];
  logic p_scl = 1'b1, p_sda = 1'b1;
  int   tdiv = 0;

  function automatic logic [7:0] rfun(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    wlog_cnt = 0; start_cnt = 0; stop_cnt = 0; mack_cnt = 0; mnack_cnt = 0;
    rise_cnt = 0; tick_since = 0; bad_iv = 0; hi_chg = 0; got_n = 0;
  endtask

  // tick source, slave model and bus monitor, all away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      tick_since += int'(tick);
      if (rd_valid && got_n < 16) begin got[got_n] = rd_data; got_n++; end
      if (p_scl && scl && p_sda != sda) hi_chg++;
      if (p_scl && scl && p_sda && !sda) begin
        start_cnt++; mode = 1; n = 0; s_pull = 1'b0; go_tx = 1'b0;
      end else if (p_scl && scl && !p_sda && sda) begin
        stop_cnt++; mode = 0; s_pull = 1'b0;
      end else if (!p_scl && scl) begin
        rise_cnt++;
        if (iv_en && rise_cnt > 1 && tick_since != 3) bad_iv++;
        tick_since = 0;
        if (mode != 0) begin
          if (mode != 4 && n < 8) rxb = {rxb[6:0], sda};
          if (mode == 4 && n == 8) begin
            m_ack = !sda;
            if (!sda) mack_cnt++; else mnack_cnt++;
          end
          n++;
        end
      end else if (p_scl && !scl && mode != 0) begin
        if (n == 8 && mode == 1) begin
          last_addr = rxb;
          if (rxb[7:1] == s_addr) begin s_pull = 1'b1; go_tx = rxb[0]; if (!rxb[0]) mode = 2; end
          else mode = 0;
        end else if (n == 8 && mode == 2) begin
          ptr = rxb; s_pull = !nack_reg; mode = 3;
        end else if (n == 8 && mode == 3) begin
          wlog_reg = ptr; wlog_data = rxb; wlog_cnt++; ptr++; s_pull = !nack_wdata;
        end else if (n == 8 && mode == 4) begin
          s_pull = 1'b0;
        end else if (n == 9) begin
          s_pull = 1'b0; n = 0;
          if (go_tx) begin
            go_tx = 1'b0; mode = 4; txb = rfun(ptr); s_pull = !txb[7];
          end else if (mode == 4) begin
            if (m_ack) begin ptr++; txb = rfun(ptr); s_pull = !txb[7]; end
            else mode = 0;
          end
        end else if (n >= 1 && n <= 7 && mode == 4) begin
          s_pull = !txb[7-n];
        end
      end
      p_scl = scl; p_sda = sda;
      tdiv = (tdiv + 1) % TICK_DIV;
      tick = !hold && (tdiv == 0);
    end
  end

  task automatic issue(input bit rd, input logic [7:0] r, input logic [7:0] w, input int len);
    @(negedge clk);
    cmd_go = 1'b1; cmd_rd = rd; cmd_reg = r; cmd_wdata = w; cmd_len = 5'(len);
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe after reset", int'(scl_oe), 0);
    chk("R1", "sda_oe after reset", int'(sda_oe), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "err after reset", int'(err), 0);
    chk("R1", "rd_valid after reset", int'(rd_valid), 0);
  endtask

  task automatic t_write(input logic [7:0] r, input logic [7:0] w);
    clear_log(); iv_en = 1'b1;
    issue(1'b0, r, w, 0);
    repeat (100) @(negedge clk);
    chk("R10", "busy mid write", int'(busy), 1);
    issue(1'b1, 8'h77, 8'h00, 3);   // must be ignored
    wait_idle(); iv_en = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10", "busy after write and stray go", int'(busy), 0);
    chk("R10", "starts after stray go", start_cnt, 1);
    chk("R5", "bytes written", wlog_cnt, 1);
    chk("R5", "register byte", int'(wlog_reg), int'(r));
    chk("R5", "data byte", int'(wlog_data), int'(w));
    chk("R5", "address byte", int'(last_addr), int'({ADDR, 1'b0}));
    chk("R5", "stop count", stop_cnt, 1);
    chk("R9", "err on acked write", int'(err), 0);
    chk("R2", "scl rises in write", rise_cnt, 28);
    chk("R2", "scl rise intervals not 3 ticks", bad_iv, 0);
    chk("R4", "sda changes with scl high (write)", hi_chg, 2);
    chk("R8", "no read strobes on write", got_n, 0);
  endtask

  task automatic t_read(input logic [7:0] r, input int len);
    int eff;
    eff = (len == 0) ? 1 : len;
    clear_log();
    issue(1'b1, r, 8'h00, len);
    wait_idle();
    chk("R8", "read byte count", got_n, eff);
    for (int i = 0; i < eff; i++)
      chk("R6", "read byte value", int'(got[i]), int'(rfun(r + 8'(i))));
    chk("R6", "start count incl repeated", start_cnt, 2);
    chk("R6", "read address byte", int'(last_addr), int'({ADDR, 1'b1}));
    chk("R6", "scl rises in read", rise_cnt, 29 + 9 * eff);
    chk("R7", "master acks", mack_cnt, eff - 1);
    chk("R7", "master final nack", mnack_cnt, 1);
    chk("R4", "sda changes with scl high (read)", hi_chg, 3);
    chk("R9", "err on good read", int'(err), 0);
  endtask

  task automatic t_hold();
    logic s_scl, s_sda, s_busy;
    int bad;
    bad = 0;
    clear_log();
    issue(1'b0, 8'h05, 8'h5A, 0);
    repeat (150) @(negedge clk);
    hold = 1'b1;
    repeat (2) @(negedge clk);
    s_scl = scl_oe; s_sda = sda_oe; s_busy = busy;
    repeat (40) begin
      @(negedge clk);
      if (scl_oe != s_scl || sda_oe != s_sda || busy != s_busy) bad++;
    end
    hold = 1'b0;
    wait_idle();
    chk("R3", "changes while tick held low", bad, 0);
    chk("R3", "busy during hold", int'(s_busy), 1);
    chk("R3", "data after hold", int'(wlog_data), 8'h5A);
    chk("R3", "register after hold", int'(wlog_reg), 8'h05);
  endtask

  task automatic t_nack_addr();
    clear_log(); s_addr = 7'h11;
    issue(1'b0, 8'h20, 8'h99, 0);
    wait_idle();
    s_addr = ADDR;
    chk("R9", "err after address nack", int'(err), 1);
    chk("R9", "no write after address nack", wlog_cnt, 0);
    chk("R9", "stop after address nack", stop_cnt, 1);
    chk("R9", "scl rises after address nack", rise_cnt, 10);
    chk("R9", "busy after address nack", int'(busy), 0);
    clear_log();
    issue(1'b1, 8'h40, 8'h00, 1);
    repeat (2) @(negedge clk);
    chk("R9", "err cleared by next command", int'(err), 0);
    wait_idle();
    chk("R9", "read ok after recovery", int'(got[0]), int'(rfun(8'h40)));
  endtask

  task automatic t_nack_data();
    clear_log(); nack_wdata = 1'b1;
    issue(1'b0, 8'h31, 8'hE4, 0);
    wait_idle();
    nack_wdata = 1'b0;
    chk("R9", "err after data nack", int'(err), 1);
    chk("R9", "stop after data nack", stop_cnt, 1);
    clear_log(); nack_reg = 1'b1;
    issue(1'b1, 8'h31, 8'h00, 2);
    wait_idle();
    nack_reg = 1'b0;
    chk("R9", "err after register nack", int'(err), 1);
    chk("R9", "no repeated start after register nack", start_cnt, 1);
    chk("R9", "no read bytes after register nack", got_n, 0);
    chk("R9", "stop after register nack", stop_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_write(8'h2B, 8'hC7);
    t_read(8'h10, 1);
    t_read(8'hFE, 4);
    t_read(8'h63, 0);
    t_hold();
    t_nack_addr();
    t_nack_data();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule